// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control half of an 8-bit successive-approximation converter. A start strobe is handled on both edges: while the strobe is high the block is held in a cleared, armed condition with its busy flag raised. When the strobe falls the block runs the binary search. That search begins with the most significant bit and ends with the least significant bit. Each trial sets one bit of the working code. After a fixed number of clocks the block samples a comparator decision and either keeps that bit or drops it. The analog parts are outside this block. The comparator decision comes in on an input pin, and the working code is what an external DAC would turn into a voltage.

The output bus is modelled as a three-state driver: a data value plus an enable flag. The enable is active whenever the active-low read strobe is low. While the bus is enabled it shows the working code as it stands, so partial codes are visible if the bus is read in mid-conversion. A start strobe narrower than a minimum number of clocks is treated as a protocol error. It raises an error pulse, and the search does not start.

States: ST_IDLE (nothing pending, code cleared), ST_ARMED (strobe high, code cleared, busy), ST_TRIAL (search running, busy), ST_HOLD (search done, code frozen). Transitions: a strobe rise goes from any state to ST_ARMED. A fall from ST_ARMED goes to ST_TRIAL if the strobe was wide enough, and to ST_IDLE with an error pulse if it was not. The last decision in ST_TRIAL goes to ST_HOLD.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, ready_o is 0, pulse_err_o is 0 and the working code is 0. With de_n_i low, data_o reads 0.
- R2: On the clock edge where convert_i is first sampled high, the working code is cleared to 0 and ready_o reads 1 after that edge.
- R3: On the edge where convert_i is first sampled low after a valid pulse, the search starts and the working code becomes 0x80, which is bit 7 set alone.
- R4: Bits are decided from bit 7 down to bit 0, one every STEP_CYC clocks. On each decision edge the bit under trial is kept if cmp_keep_i is 1 and cleared if it is 0, and the next lower bit is set as the new trial bit.
- R5: ready_o stays 1 throughout the search and drops to 0 exactly WIDTH*STEP_CYC clock edges after the edge that started it.
- R6: Once the search is complete, the code does not change, whatever cmp_keep_i does, until the next rise of convert_i.
- R7: data_oe_o is 1 exactly while de_n_i is 0. While data_oe_o is 0, data_o reads 0.
- R8: If the bus is enabled during a search, data_o shows the current working code, with the decided upper bits and the current trial bit set.
- R9: A pulse on convert_i that is sampled high on fewer than MIN_PULSE_CYC edges raises pulse_err_o for exactly one cycle after its falling edge, leaves ready_o at 0 and does not start a search. The code stays 0.
- R10: A rise of convert_i during a search aborts it. The code is cleared, ready_o stays 1, and the next fall starts a new search from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| convert_i | input | 1 | Start strobe: rise clears and arms, fall starts the search |
| de_n_i | input | 1 | Active-low output enable for the data bus |
| cmp_keep_i | input | 1 | Comparator decision: 1 keeps the bit under trial |
| ready_o | output | 1 | Busy flag, high from the strobe rise until the search ends |
| pulse_err_o | output | 1 | One-cycle flag for a start strobe that was too narrow |
| data_oe_o | output | 1 | Three-state enable for the data bus model |
| data_o | output | WIDTH | Bus value, the working code while enabled and 0 otherwise |

## Verification
Conversions are run with fixed codes at the extremes (0, 255, an alternating pattern) and with random codes. The comparator is modelled in the bench as an ideal one, so a correct search must return exactly the chosen code: this exposes wrong bit order and wrong keep polarity. Some runs keep the bus enabled throughout, which shows every partial code and exposes an off-by-one step count. Pulse widths of exactly the minimum and one clock less separate a correct threshold from a shifted one. A second strobe issued mid-search, and comparator noise after completion, test abort and hold.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_TRIAL = 2'd2,
        ST_HOLD  = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_edge_detect.sv
module sar_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_i;
        end
    end

    assign rise_o = level_i & ~level_q;
    assign fall_o = ~level_i & level_q;

endmodule

// File: rtl/sar_width_counter.sv
module sar_width_counter #(
    parameter int LIMIT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic count_en_i,
    output logic reached_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // The edge that clears the counter already sees the strobe high, so it counts as one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= CW'(1);
        end else if (count_en_i && (cnt_q < LIMIT_V)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached_o = (cnt_q >= LIMIT_V);

endmodule

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
    parameter int STEP_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic tick_o
);

    localparam int TW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [TW-1:0] LAST_V = TW'(STEP_CYC - 1);

    logic [TW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST_V);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            if (tick_o) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             start_i,
    input  logic             decide_i,
    input  logic             keep_i,
    output logic [WIDTH-1:0] code_o,
    output logic             last_o
);

    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IW-1:0] MSB_IDX = IW'(WIDTH - 1);

    logic [WIDTH-1:0] code_q;
    logic [WIDTH-1:0] code_nxt;
    logic [IW-1:0]    idx_q;
    logic [IW-1:0]    idx_nxt;

    always_comb begin
        code_nxt = code_q;
        idx_nxt  = idx_q;
        if (clear_i) begin
            code_nxt = '0;
            idx_nxt  = MSB_IDX;
        end else if (start_i) begin
            code_nxt          = '0;
            code_nxt[MSB_IDX] = 1'b1;
            idx_nxt           = MSB_IDX;
        end else if (decide_i) begin
            code_nxt[idx_q] = keep_i;
            if (idx_q != '0) begin
                code_nxt[idx_q - 1'b1] = 1'b1;
                idx_nxt                = idx_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            idx_q  <= MSB_IDX;
        end else begin
            code_q <= code_nxt;
            idx_q  <= idx_nxt;
        end
    end

    assign code_o = code_q;
    assign last_o = (idx_q == '0);

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
    parameter int WIDTH         = 8,
    parameter int MIN_PULSE_CYC = 50,
    parameter int STEP_CYC      = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             convert_i,
    input  logic             de_n_i,
    input  logic             cmp_keep_i,
    output logic             ready_o,
    output logic             pulse_err_o,
    output logic             data_oe_o,
    output logic [WIDTH-1:0] data_o
);

    import sar_seq_pkg::*;

    sar_state_e       state_q;
    sar_state_e       state_nxt;
    logic             cv_rise;
    logic             cv_fall;
    logic             width_ok;
    logic             step_tick;
    logic             last_bit;
    logic             do_start;
    logic             do_decide;
    logic             short_pulse;
    logic             err_q;
    logic [WIDTH-1:0] result_q;

    sar_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (convert_i),
        .rise_o  (cv_rise),
        .fall_o  (cv_fall)
    );

    sar_width_counter #(.LIMIT(MIN_PULSE_CYC)) u_width (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (cv_rise),
        .count_en_i ((state_q == ST_ARMED) && convert_i),
        .reached_o  (width_ok)
    );

    sar_step_timer #(.STEP_CYC(STEP_CYC)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (do_start),
        .run_i     (state_q == ST_TRIAL),
        .tick_o    (step_tick)
    );

    sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (cv_rise),
        .start_i  (do_start),
        .decide_i (do_decide),
        .keep_i   (cmp_keep_i),
        .code_o   (result_q),
        .last_o   (last_bit)
    );

    assign do_start    = (state_q == ST_ARMED) && cv_fall && width_ok;
    assign short_pulse = (state_q == ST_ARMED) && cv_fall && !width_ok;
    assign do_decide   = (state_q == ST_TRIAL) && step_tick && !cv_rise;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            err_q   <= short_pulse;
        end
    end

    // Next-state logic; a strobe rise wins in every state
    always_comb begin
        state_nxt = state_q;
        if (cv_rise) begin
            state_nxt = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_ARMED: begin
                    if (cv_fall) begin
                        state_nxt = width_ok ? ST_TRIAL : ST_IDLE;
                    end
                end
                ST_TRIAL: begin
                    if (step_tick && last_bit) begin
                        state_nxt = ST_HOLD;
                    end
                end
                ST_HOLD:  state_nxt = ST_HOLD;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ready_o     = (state_q == ST_ARMED) || (state_q == ST_TRIAL);
        pulse_err_o = err_q;
        data_oe_o   = ~de_n_i;
        data_o      = data_oe_o ? result_q : '0;
    end

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             convert_i,
    input logic             ready_o,
    input logic             pulse_err_o,
    input logic             data_oe_o,
    input logic [WIDTH-1:0] data_o,
    input logic [WIDTH-1:0] result_q
);

    AST_BUS_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> (data_o == '0));                                       // R7

    AST_RISE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convert_i) |=> ready_o);                                        // R2

    AST_RISE_CLEARS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convert_i) |=> (result_q == '0));                               // R2

    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_err_o |-> !ready_o);                                            // R9

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_err_o |=> !pulse_err_o);                                        // R9

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !convert_i) |=> $stable(result_q));                      // R6

endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .convert_i   (convert_i),
    .ready_o     (ready_o),
    .pulse_err_o (pulse_err_o),
    .data_oe_o   (data_oe_o),
    .data_o      (data_o),
    .result_q    (result_q)
);

// File: tb/sar_seq_ctrl_bench.sv
module sar_seq_ctrl_bench;

    localparam int W    = 8;
    localparam int MINW = 50;
    localparam int STEP = 25;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         convert = 1'b0;
    logic         de_n = 1'b1;
    logic         cmp = 1'b0;
    logic         ready;
    logic         perr;
    logic         oe;
    logic [W-1:0] data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sar_seq_ctrl #(.WIDTH(W), .MIN_PULSE_CYC(MINW), .STEP_CYC(STEP)) u_sar_seq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .convert_i   (convert),
        .de_n_i      (de_n),
        .cmp_keep_i  (cmp),
        .ready_o     (ready),
        .pulse_err_o (perr),
        .data_oe_o   (oe),
        .data_o      (data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit keep_of(input int trial, input int vin);
        return trial <= vin;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Strobe of 'width' high edges, then a fall; ends at the negedge after the fall edge.
    task automatic strobe(input int width, input bit bus_on);
        @(negedge clk);
        de_n = ~bus_on;
        convert = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2 ready after rise", ready, 1);
        if (bus_on) check("R2 code cleared", data, 0);
        repeat (width - 1) @(posedge clk);
        @(negedge clk);
        convert = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Full or partial search; stop_after < W aborts early.
    task automatic convert_run(input int vin, input int width, input bit bus_on, input int stop_after);
        int acc = 0;
        strobe(width, bus_on);
        if (bus_on) check("R3 first trial", data, 32'h80);
        for (int k = 0; k < W; k++) begin
            int b = W - 1 - k;
            int trial = acc | (1 << b);
            if (k == stop_after) return;
            cmp = keep_of(trial, vin);
            if (bus_on) check("R8 partial code", data, trial);
            repeat (STEP) @(posedge clk);
            @(negedge clk);
            if (cmp) acc = trial;
            check("R5 ready timing", ready, (b > 0) ? 1 : 0);
        end
        de_n = 1'b0;
        #1;
        check("R4 final code", data, vin);
        check("R7 enable on", oe, 1);
        // R6: comparator noise after completion
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            cmp = $urandom_range(0, 1);
            check("R6 code held", data, vin);
        end
        de_n = 1'b1;
        #1;
        check("R7 enable off", oe, 0);
        check("R7 bus zero", data, 0);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd1234);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 ready", ready, 0);
        check("R1 err", perr, 0);
        rst_n = 1'b1;
        de_n = 1'b0;
        #1;
        check("R1 code zero", data, 0);
        check("R7 enable follows", oe, 1);
        de_n = 1'b1;

        // Directed codes
        convert_run(0,     MINW, 1'b1, W);
        convert_run(255,   MINW, 1'b0, W);
        convert_run(8'hA5, MINW + 3, 1'b1, W);
        convert_run(8'h5A, MINW, 1'b1, W);

        // R9: one clock short
        strobe(MINW - 1, 1'b1);
        check("R9 err raised", perr, 1);
        check("R9 not busy", ready, 0);
        check("R9 code zero", data, 0);
        @(negedge clk);
        check("R9 err single", perr, 0);
        repeat (2 * STEP) @(posedge clk);
        @(negedge clk);
        check("R9 no search", data, 0);
        de_n = 1'b1;

        // R10: abort mid-search, then a full search
        convert_run(8'h3C, MINW, 1'b1, 3);
        convert_run(8'hC3, MINW, 1'b1, W);

        // Random codes and widths
        for (int i = 0; i < 20; i++) begin
            convert_run($urandom_range(0, 255), MINW + $urandom_range(0, 20),
                        bit'($urandom_range(0, 1)), W);
        end
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule